// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block owns a small on-chip table of transmit descriptors and walks it as a ring. Each entry has a 16-bit flag word, a 16-bit byte count and a 32-bit buffer address. Software fills entries through a write port and sets their ready flag. It then pulses `kick`, which raises the `active` flag. The sequencer reads entries one at a time, in index order. For each ready entry it offers the address, byte count and the end-of-frame and append-CRC flags on a valid/ready frame stream. When the stream accepts the frame, the sequencer writes the entry's flag word back with the ready flag cleared and moves to the next index.

A non-ready entry ends the walk and drops `active`. The engine stays parked on that index until the next `kick`. An entry whose wrap flag is set sends the next read to `ring_base`; otherwise the index steps by one, modulo the table depth. Dropping `enable` reloads the index from `ring_base` and abandons the walk. A graceful-stop request lets the frame in flight finish and then reports completion with a one-cycle `stop_done` pulse.

Frame stream rules: a frame is transferred on a clock edge where `fo_valid` and `fo_ready` are both high. While `fo_valid` is high and `fo_ready` is low, the sequencer holds `fo_valid` and every frame field steady. `fo_ready` may stay low for any number of cycles.

Top module: `tx_bd_ring`

## Requirements
- R1: Flag word encoding: bit 0 is READY, bit 1 is WRAP, bit 2 is LAST and bit 3 is CRC. A sent frame carries the entry's address on `fo_ptr`, its byte count on `fo_len`, bit 3 on `fo_crc` and bit 2 on `fo_last`.
- R2: A `kick` while `enable` is high sets `active`. The ready entries are then offered in ascending index order, starting at the current index.
- R3: Once a frame is accepted, its entry's flag word reads back with READY at 0 and all other bits unchanged.
- R4: Reading a non-ready entry clears `active` and stops reading. No further frame is offered until the next `kick`.
- R5: After an entry with WRAP set, the next index is `ring_base`. Otherwise the next index is the current index plus one, wrapping from DEPTH-1 to 0.
- R6: A lone entry with WRAP and READY set, at index `ring_base`, is sent exactly once per `kick`.
- R7: While `enable` is low, `active` stays 0, `kick` has no effect, no frame is offered, and the index is reloaded from `ring_base`.
- R8: While `fo_valid` is high and `fo_ready` is low, `fo_valid`, `fo_ptr` and `fo_len` hold their values. Exactly one frame is counted per handshake.
- R9: After a one-cycle `stop_req`, the frame in flight completes and then `stop_done` pulses for one cycle. `active` clears, and later ready entries stay ready and unsent.
- R10: `active` stays high from the acceptance of a frame until that frame's READY writeback is committed.
- R11: After reset, `active`, `fo_valid` and `stop_done` are 0, and every flag word reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low reloads the index from ring_base |
| ring_base | input | IDXW | Ring start index |
| kick | input | 1 | One-cycle start pulse |
| stop_req | input | 1 | One-cycle graceful-stop request |
| active | output | 1 | Descriptor processing in progress |
| stop_done | output | 1 | One-cycle graceful-stop completion event |
| dw_en | input | 1 | Descriptor write strobe |
| dw_idx | input | IDXW | Descriptor write index |
| dw_status | input | 16 | Flag word to write |
| dw_len | input | LENW | Byte count to write |
| dw_ptr | input | PTRW | Buffer address to write |
| dr_idx | input | IDXW | Flag word read-back index |
| dr_status | output | 16 | Flag word at dr_idx (combinational) |
| fo_valid | output | 1 | Frame offer valid |
| fo_ready | input | 1 | Frame sink ready |
| fo_ptr | output | PTRW | Frame buffer address |
| fo_len | output | LENW | Frame byte count |
| fo_crc | output | 1 | Append CRC to this frame |
| fo_last | output | 1 | Last buffer of the frame |

## Verification
A `kick` is registered on the next edge. The walk leaves idle one edge later, reads the entry on the edge after that, and `fo_valid` rises after a further edge: four edges after the kick. A handshake is followed one edge later by the READY writeback, which `dr_status` shows combinationally. The next entry's offer comes three edges after that, and `stop_done` coincides with the writeback edge. Because back-pressure makes these counts vary, the checks do not sample at fixed cycles. They collect handshakes with a monitor at the falling edge and then poll `active` at falling edges with a bounded wait. Each expected frame list, flag word and event count is compared only once the sequencer has gone idle.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int FLAG_W  = 16;
  localparam int B_READY = 0;
  localparam int B_WRAP  = 1;
  localparam int B_LAST  = 2;
  localparam int B_CRC   = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_CHECK,
    S_SEND,
    S_WB
  } seq_t;
endpackage

// File: rtl/tbd_store.sv
module tbd_store
  import tbd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDXW  = $clog2(DEPTH),
  parameter int LENW  = 16,
  parameter int PTRW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [IDXW-1:0]   sw_idx,
  input  logic [FLAG_W-1:0] sw_status,
  input  logic [LENW-1:0]   sw_len,
  input  logic [PTRW-1:0]   sw_ptr,
  input  logic [IDXW-1:0]   sw_rd_idx,
  output logic [FLAG_W-1:0] sw_rd_status,
  input  logic              wb_en,
  input  logic [IDXW-1:0]   wb_idx,
  input  logic [FLAG_W-1:0] wb_status,
  input  logic              rd_en,
  input  logic [IDXW-1:0]   rd_idx,
  output logic [FLAG_W-1:0] rd_status,
  output logic [LENW-1:0]   rd_len,
  output logic [PTRW-1:0]   rd_ptr
);
  logic [FLAG_W-1:0] st_mem  [DEPTH];
  logic [LENW-1:0]   len_mem [DEPTH];
  logic [PTRW-1:0]   ptr_mem [DEPTH];

  assign sw_rd_status = st_mem[sw_rd_idx];

  // Engine writeback is applied after the software write, so it wins on a
  // same-index collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_mem[i]  <= '0;
        len_mem[i] <= '0;
        ptr_mem[i] <= '0;
      end
      rd_status <= '0;
      rd_len    <= '0;
      rd_ptr    <= '0;
    end else begin
      if (sw_we) begin
        st_mem[sw_idx]  <= sw_status;
        len_mem[sw_idx] <= sw_len;
        ptr_mem[sw_idx] <= sw_ptr;
      end
      if (wb_en) st_mem[wb_idx] <= wb_status;
      if (rd_en) begin
        rd_status <= st_mem[rd_idx];
        rd_len    <= len_mem[rd_idx];
        rd_ptr    <= ptr_mem[rd_idx];
      end
    end
  end
endmodule

// File: rtl/tbd_step.sv
module tbd_step #(
  parameter int DEPTH = 8,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic [IDXW-1:0] cur,
  input  logic [IDXW-1:0] base,
  input  logic            wrap,
  output logic [IDXW-1:0] nxt
);
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(DEPTH - 1);

  always_comb begin
    if (wrap)                nxt = base;
    else if (cur == TOP_IDX) nxt = '0;
    else                     nxt = cur + 1'b1;
  end
endmodule

// File: rtl/tbd_seq.sv
module tbd_seq
  import tbd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [IDXW-1:0]   ring_base,
  input  logic              kick,
  input  logic              stop_req,
  input  logic              fo_ready,
  input  logic [FLAG_W-1:0] rd_status,
  output logic              rd_en,
  output logic [IDXW-1:0]   rd_idx,
  output logic              wb_en,
  output logic [IDXW-1:0]   wb_idx,
  output logic [FLAG_W-1:0] wb_status,
  output logic              fo_valid,
  output logic              active,
  output logic              stop_done
);
  seq_t            st;
  logic [IDXW-1:0] idx;
  logic [IDXW-1:0] nxt;
  logic            stop_pend;

  tbd_step #(.DEPTH(DEPTH), .IDXW(IDXW)) u_step (
    .cur  (idx),
    .base (ring_base),
    .wrap (rd_status[B_WRAP]),
    .nxt  (nxt)
  );

  assign rd_en     = (st == S_FETCH);
  assign rd_idx    = idx;
  assign wb_en     = (st == S_WB);
  assign wb_idx    = idx;
  assign wb_status = rd_status & ~(FLAG_W'(1) << B_READY);
  assign fo_valid  = (st == S_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      active    <= 1'b0;
      stop_pend <= 1'b0;
      stop_done <= 1'b0;
    end else if (!enable) begin
      st        <= S_IDLE;
      idx       <= ring_base;
      active    <= 1'b0;
      stop_pend <= 1'b0;
      stop_done <= 1'b0;
    end else begin
      stop_done <= 1'b0;
      if (kick)     active    <= 1'b1;
      if (stop_req) stop_pend <= 1'b1;
      unique case (st)
        S_IDLE: begin
          if (stop_pend || stop_req) begin
            stop_pend <= 1'b0;
            stop_done <= 1'b1;
            active    <= 1'b0;
          end else if (active) begin
            st <= S_FETCH;
          end
        end
        S_FETCH: st <= S_CHECK;
        S_CHECK: begin
          if (rd_status[B_READY]) begin
            st <= S_SEND;
          end else begin
            // A kick arriving with the empty entry keeps the walk alive.
            active <= kick;
            st     <= S_IDLE;
          end
        end
        S_SEND: if (fo_ready) st <= S_WB;
        S_WB: begin
          // READY is cleared this cycle, before the next read of any entry.
          idx <= nxt;
          if (stop_pend || stop_req) begin
            stop_pend <= 1'b0;
            stop_done <= 1'b1;
            active    <= 1'b0;
            st        <= S_IDLE;
          end else begin
            st <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_bd_ring.sv
module tx_bd_ring
  import tbd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDXW  = $clog2(DEPTH),
  parameter int LENW  = 16,
  parameter int PTRW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [IDXW-1:0]   ring_base,
  input  logic              kick,
  input  logic              stop_req,
  output logic              active,
  output logic              stop_done,
  input  logic              dw_en,
  input  logic [IDXW-1:0]   dw_idx,
  input  logic [15:0]       dw_status,
  input  logic [LENW-1:0]   dw_len,
  input  logic [PTRW-1:0]   dw_ptr,
  input  logic [IDXW-1:0]   dr_idx,
  output logic [15:0]       dr_status,
  output logic              fo_valid,
  input  logic              fo_ready,
  output logic [PTRW-1:0]   fo_ptr,
  output logic [LENW-1:0]   fo_len,
  output logic              fo_crc,
  output logic              fo_last
);
  logic              rd_en;
  logic [IDXW-1:0]   rd_idx;
  logic [FLAG_W-1:0] rd_status;
  logic              wb_en;
  logic [IDXW-1:0]   wb_idx;
  logic [FLAG_W-1:0] wb_status;

  tbd_store #(.DEPTH(DEPTH), .IDXW(IDXW), .LENW(LENW), .PTRW(PTRW)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_we        (dw_en),
    .sw_idx       (dw_idx),
    .sw_status    (dw_status),
    .sw_len       (dw_len),
    .sw_ptr       (dw_ptr),
    .sw_rd_idx    (dr_idx),
    .sw_rd_status (dr_status),
    .wb_en        (wb_en),
    .wb_idx       (wb_idx),
    .wb_status    (wb_status),
    .rd_en        (rd_en),
    .rd_idx       (rd_idx),
    .rd_status    (rd_status),
    .rd_len       (fo_len),
    .rd_ptr       (fo_ptr)
  );

  tbd_seq #(.DEPTH(DEPTH), .IDXW(IDXW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .ring_base (ring_base),
    .kick      (kick),
    .stop_req  (stop_req),
    .fo_ready  (fo_ready),
    .rd_status (rd_status),
    .rd_en     (rd_en),
    .rd_idx    (rd_idx),
    .wb_en     (wb_en),
    .wb_idx    (wb_idx),
    .wb_status (wb_status),
    .fo_valid  (fo_valid),
    .active    (active),
    .stop_done (stop_done)
  );

  assign fo_crc  = rd_status[B_CRC];
  assign fo_last = rd_status[B_LAST];
endmodule

// File: rtl/tbd_ring_chk.sv
module tbd_ring_chk #(
  parameter int LENW = 16,
  parameter int PTRW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            active,
  input logic            stop_done,
  input logic            fo_valid,
  input logic            fo_ready,
  input logic [PTRW-1:0] fo_ptr,
  input logic [LENW-1:0] fo_len
);
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_valid && !fo_ready && enable) |=> (!enable || (fo_valid && $stable(fo_ptr) && $stable(fo_len)))); // R8
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_valid && fo_ready) |=> !fo_valid); // R6
  AST_HELD_THROUGH_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_valid && fo_ready && enable) |=> (active || !enable)); // R10
  AST_OFFER_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid |-> active); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!active && !fo_valid && !stop_done)); // R7
endmodule

bind tx_bd_ring tbd_ring_chk #(.LENW(LENW), .PTRW(PTRW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .active    (active),
  .stop_done (stop_done),
  .fo_valid  (fo_valid),
  .fo_ready  (fo_ready),
  .fo_ptr    (fo_ptr),
  .fo_len    (fo_len)
);

// File: tb/tb_tx_bd_ring.sv
module tb_tx_bd_ring;
  localparam int DEPTH = 8;
  localparam int IDXW  = 3;
  localparam logic [15:0] F_R = 16'h1, F_W = 16'h2, F_L = 16'h4, F_C = 16'h8;

  logic clk = 0, rst_n = 0, enable = 0, kick = 0, stop_req = 0;
  logic [IDXW-1:0] ring_base = '0, dw_idx = '0, dr_idx = '0;
  logic dw_en = 0, fo_ready = 1;
  logic [15:0] dw_status = '0, dw_len = '0, dr_status, fo_len;
  logic [31:0] dw_ptr = '0, fo_ptr;
  logic active, stop_done, fo_valid, fo_crc, fo_last;

  always #2 clk = ~clk;

  tx_bd_ring dut (.*);

  int nchk = 0, nfail = 0, ncap = 0, ndone = 0;
  logic [31:0] cap_ptr [64];
  logic [15:0] cap_len [64];
  logic        cap_crc [64];
  logic        cap_last[64];

  always @(negedge clk) begin
    if (fo_valid && fo_ready && ncap < 64) begin
      cap_ptr[ncap] = fo_ptr; cap_len[ncap] = fo_len;
      cap_crc[ncap] = fo_crc; cap_last[ncap] = fo_last;
      ncap++;
    end
    if (stop_done) ndone++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic set_desc(input int i, input logic [15:0] s, input logic [15:0] l, input logic [31:0] p);
    tick(); dw_en = 1; dw_idx = IDXW'(i); dw_status = s; dw_len = l; dw_ptr = p;
    tick(); dw_en = 0;
  endtask

  task automatic pulse_kick(); tick(); kick = 1; tick(); kick = 0; endtask

  task automatic wait_idle(input string tag);
    repeat (5) tick();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!active) break;
    end
    chk({tag, " idle"}, active, 0);
  endtask

  task automatic read_flags(input int i, output logic [15:0] v);
    tick(); dr_idx = IDXW'(i); @(negedge clk); v = dr_status;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    @(negedge clk);
    chk("R11 active", active, 0);
    chk("R11 fo_valid", fo_valid, 0);
    chk("R11 stop_done", stop_done, 0);
    read_flags(4, v); chk("R11 flags", v, 0);
  endtask

  task automatic t_run();
    int b = ncap;
    logic [15:0] v;
    set_desc(0, F_R | F_C, 100, 32'h1000);
    set_desc(1, F_R, 200, 32'h2000);
    set_desc(2, F_R | F_L | F_C, 300, 32'h3000);
    pulse_kick();
    wait_idle("R4 run");
    chk("R2 count", ncap - b, 3);
    chk("R2 order0", cap_ptr[b], 32'h1000);
    chk("R2 order1", cap_ptr[b+1], 32'h2000);
    chk("R1 ptr2", cap_ptr[b+2], 32'h3000);
    chk("R1 len1", cap_len[b+1], 200);
    chk("R1 crc0", cap_crc[b], 1);
    chk("R1 crc1", cap_crc[b+1], 0);
    chk("R1 last2", cap_last[b+2], 1);
    chk("R1 last0", cap_last[b], 0);
    read_flags(2, v); chk("R3 flags2", v, F_L | F_C);
    read_flags(0, v); chk("R3 flags0", v, F_C);
    repeat (10) tick();
    chk("R4 no more", ncap - b, 3);
  endtask

  task automatic t_wrap();
    int b = ncap;
    set_desc(3, F_R | F_W, 40, 32'h4000);
    set_desc(0, F_R, 50, 32'h5000);
    pulse_kick();
    wait_idle("R5 wrap");
    chk("R5 count", ncap - b, 2);
    chk("R5 first", cap_ptr[b], 32'h4000);
    chk("R5 to base", cap_ptr[b+1], 32'h5000);
  endtask

  task automatic t_single();
    int b = ncap;
    logic [15:0] v;
    tick(); enable = 0; ring_base = 3'd5;
    tick(); enable = 1;
    set_desc(5, F_R | F_W | F_L, 64, 32'h6000);
    pulse_kick();
    wait_idle("R6 single");
    repeat (20) tick();
    chk("R6 once", ncap - b, 1);
    chk("R7 base reload", cap_ptr[b], 32'h6000);
    read_flags(5, v); chk("R6 flags", v, F_W | F_L);
  endtask

  task automatic t_backpressure();
    int b = ncap;
    set_desc(5, F_R, 77, 32'h7000);
    fo_ready = 0;
    pulse_kick();
    repeat (20) tick();
    @(negedge clk);
    chk("R8 held valid", fo_valid, 1);
    chk("R8 held ptr", fo_ptr, 32'h7000);
    chk("R8 held len", fo_len, 77);
    chk("R10 active", active, 1);
    chk("R8 no xfer", ncap - b, 0);
    tick(); fo_ready = 1;
    wait_idle("R8 bp");
    chk("R8 one xfer", ncap - b, 1);
  endtask

  task automatic t_disabled();
    int b = ncap;
    logic [15:0] v;
    tick(); enable = 0;
    set_desc(5, F_R, 10, 32'h8000);
    set_desc(6, F_R, 20, 32'h9000);
    pulse_kick();
    repeat (10) tick();
    @(negedge clk);
    chk("R7 active", active, 0);
    chk("R7 no frame", ncap - b, 0);
    read_flags(5, v); chk("R7 untouched", v, F_R);
    tick(); enable = 1;
  endtask

  task automatic t_stop();
    int b = ncap, d = ndone;
    logic [15:0] v;
    fo_ready = 0;
    pulse_kick();
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (fo_valid) break;
    end
    tick(); stop_req = 1; tick(); stop_req = 0;
    repeat (3) tick();
    fo_ready = 1;
    wait_idle("R9 stop");
    repeat (10) tick();
    chk("R9 one frame", ncap - b, 1);
    chk("R9 frame ptr", cap_ptr[b], 32'h8000);
    chk("R9 done pulse", ndone - d, 1);
    read_flags(6, v); chk("R9 next still ready", v, F_R);
    pulse_kick();
    wait_idle("R9 resume");
    chk("R9 resume count", ncap - b, 2);
    chk("R9 resume ptr", cap_ptr[b+1], 32'h9000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    t_reset();
    tick(); enable = 1;
    t_run();
    t_wrap();
    t_single();
    t_backpressure();
    t_disabled();
    t_stop();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule